// File: doc/BRIEF.md
# Descriptor-List Stream DMA Position Engine

This block moves audio sample bytes for a set of independent streams. A codec-side requester asks for a transfer by giving a 4-bit stream tag, a direction and a byte count. The engine finds the stream whose control word carries that tag. It then walks that stream's descriptor list, a ring of memory regions each with a length and an interrupt-on-completion flag. For every piece of the request it issues one memory operation. While doing so it keeps track of the link position inside the stream's cyclic buffer.

A transfer is split wherever the request ends, the cyclic buffer wraps, or the current descriptor entry runs out. When an entry flagged for completion is used up, the stream's completion status is raised at the end of the transfer. While that status is set, the stream refuses all further transfers until software clears it. If enabled, the final link position is also written back to a per-stream slot of a position buffer in memory.

The descriptor entries are held in a store outside the block. The engine addresses that store with a stream and entry index and reads the address, length and flag back in the same cycle.

Top module: `sdma_engine`

## Requirements
- R1: A request is routed to the lowest-numbered stream whose control bits 23:20 equal `req_tag`. The match does not depend on the run bit. With no match the request is refused: `done` is high with `done_ok` low, and no memory operation is issued.
- R2: A request that matches a stream whose run bit (control bit 1) is clear, or whose completion bit (control bit 26) is set, is refused the same way, and that stream's link position does not change.
- R3: Each memory operation moves the smallest of three byte counts: the bytes left in the request, the cyclic buffer length minus the link position, and the entry length minus the offset within the entry.
- R4: The link position grows by each operation's length and becomes 0 when it reaches the cyclic buffer length.
- R5: Each operation's address is the entry address plus the offset within the entry. When an entry is used up, the engine moves to the next entry and the offset returns to 0. After the entry whose index equals the last-valid index, it returns to entry 0.
- R6: Using up an entry whose flag is set raises control bit 26 on the clock edge that ends the `done` cycle. Bit 26 is not raised by entries without the flag.
- R7: When `pos_base` bit 0 is set, a successful transfer's `done` cycle also carries `wb_valid`. The address is `pos_base` with bit 0 cleared plus 8 times the stream index, and the data is the final link position. With bit 0 clear, nothing is written back.
- R8: A register write selects a field with `reg_field`: 0 is control, 1 is cyclic buffer length, 2 is last-valid index. A control write stores the written bits under mask 0x00F0001F, leaves every other bit alone, and clears each of bits 28:26 that is written as 1.
- R9: A control write with bit 0 set returns the stream's link position, entry index and entry offset to 0.
- R10: A control write that takes the run bit from 0 to 1 returns the entry index and offset to 0 and keeps the link position.
- R11: Requests are taken only while `idle` is high. Memory operations come one per cycle, starting the cycle after the request is taken. `done` is high for exactly one cycle: the cycle after the last operation, or the cycle after the request for a refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SEL_W | Stream selected for the write |
| reg_field | input | 2 | Field: 0 control, 1 buffer length, 2 last-valid index |
| reg_wdata | input | 32 | Write data |
| pos_base | input | 32 | Position buffer base; bit 0 enables write-back |
| rd_sel | input | SEL_W | Stream shown on the read outputs |
| rd_ctl | output | 32 | Control word of the selected stream |
| rd_lpib | output | LEN_W | Link position of the selected stream |
| req_valid | input | 1 | Transfer request |
| req_tag | input | 4 | Requested stream tag |
| req_dir | input | 1 | Direction, passed to the memory operations |
| req_len | input | LEN_W | Requested byte count |
| idle | output | 1 | Engine can take a request |
| done | output | 1 | Transfer ended (one cycle) |
| done_ok | output | 1 | Transfer was carried out, not refused |
| desc_stream | output | SEL_W | Stream index for the descriptor store |
| desc_entry | output | ENT_W | Entry index for the descriptor store |
| desc_addr | input | 64 | Entry memory address |
| desc_len | input | LEN_W | Entry length in bytes |
| desc_ioc | input | 1 | Entry completion flag |
| mem_valid | output | 1 | Memory operation this cycle |
| mem_dir | output | 1 | Direction of the operation |
| mem_addr | output | 64 | Operation address |
| mem_len | output | LEN_W | Operation byte count |
| wb_valid | output | 1 | Position write-back this cycle |
| wb_addr | output | 32 | Write-back address |
| wb_data | output | LEN_W | Write-back data (link position) |

## Verification
A request is taken on the edge where it is presented. Its first memory operation can be seen in the next cycle and continues one per cycle. `done` comes in the cycle after the last operation, or in the cycle right after the request for a refusal. The write-back appears in that same `done` cycle, and the completion bit and the new positions are visible only one edge later. The bench drives and samples on falling edges. It collects every operation cycle by cycle, checks the cycle index of the first operation and of `done`, and reads status and positions one cycle after `done`.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int TAG_LSB  = 20;
    localparam int SRST_BIT = 0;
    localparam int RUN_BIT  = 1;
    localparam int CMPL_BIT = 26;
    localparam logic [31:0] CTL_WMASK = 32'h00F0_001F;
    localparam logic [31:0] CTL_W1C   = 32'h1C00_0000;

    localparam logic [1:0] FLD_CTL = 2'd0;
    localparam logic [1:0] FLD_CBL = 2'd1;
    localparam logic [1:0] FLD_LVI = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_FIN  = 2'd2,
        ST_REJ  = 2'd3
    } fsm_e;
endpackage

// File: rtl/sdma_tag_match.sv
module sdma_tag_match #(
    parameter int NUM_STREAMS = 2,
    parameter int SEL_W       = 1
) (
    input  logic [NUM_STREAMS-1:0][3:0] tags,
    input  logic [3:0]                  want,
    output logic                        hit,
    output logic [SEL_W-1:0]            idx
);
    // Scan downward so the lowest matching index wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
            if (tags[i] == want) begin
                hit = 1'b1;
                idx = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/sdma_chunk.sv
module sdma_chunk #(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0] left,
    input  logic [LEN_W-1:0] cbl,
    input  logic [LEN_W-1:0] lpib,
    input  logic [LEN_W-1:0] elen,
    input  logic [LEN_W-1:0] bp,
    output logic [LEN_W-1:0] chunk,
    output logic             ent_end
);
    logic [LEN_W-1:0] room_c;
    logic [LEN_W-1:0] room_e;
    logic [LEN_W-1:0] min_a;

    always_comb begin
        room_c  = (lpib < cbl) ? (cbl - lpib) : '0;
        room_e  = (bp < elen) ? (elen - bp) : '0;
        min_a   = (left < room_c) ? left : room_c;
        chunk   = (min_a < room_e) ? min_a : room_e;
        ent_end = (chunk == room_e);
    end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine #(
    parameter int NUM_STREAMS = 2,
    parameter int LEN_W       = 32,
    parameter int ENT_W       = 8,
    localparam int SEL_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [1:0]       reg_field,
    input  logic [31:0]      reg_wdata,
    input  logic [31:0]      pos_base,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [31:0]      rd_ctl,
    output logic [LEN_W-1:0] rd_lpib,
    input  logic             req_valid,
    input  logic [3:0]       req_tag,
    input  logic             req_dir,
    input  logic [LEN_W-1:0] req_len,
    output logic             idle,
    output logic             done,
    output logic             done_ok,
    output logic [SEL_W-1:0] desc_stream,
    output logic [ENT_W-1:0] desc_entry,
    input  logic [63:0]      desc_addr,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_ioc,
    output logic             mem_valid,
    output logic             mem_dir,
    output logic [63:0]      mem_addr,
    output logic [LEN_W-1:0] mem_len,
    output logic             wb_valid,
    output logic [31:0]      wb_addr,
    output logic [LEN_W-1:0] wb_data
);
    import sdma_pkg::*;

    typedef struct packed {
        logic [31:0]      ctl;
        logic [LEN_W-1:0] cbl;
        logic [ENT_W-1:0] lvi;
        logic [LEN_W-1:0] lpib;
        logic [ENT_W-1:0] be;
        logic [LEN_W-1:0] bp;
    } strm_t;

    typedef struct packed {
        fsm_e                        fsm;
        logic [SEL_W-1:0]            cur;
        logic [LEN_W-1:0]            left;
        logic                        dir;
        logic                        pend;
        strm_t [NUM_STREAMS-1:0]     s;
    } eng_t;

    eng_t st_q, st_d;

    logic [NUM_STREAMS-1:0][3:0] tags;
    logic                        hit;
    logic [SEL_W-1:0]            hit_idx;
    logic [LEN_W-1:0]            chunk;
    logic                        ent_end;
    logic [31:0]                 old_c, new_c;
    logic [LEN_W-1:0]            nxt_lpib, nxt_bp, nxt_left;
    strm_t                       cs;

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_tags
        assign tags[g] = st_q.s[g].ctl[TAG_LSB+3:TAG_LSB];
    end

    sdma_tag_match #(.NUM_STREAMS(NUM_STREAMS), .SEL_W(SEL_W)) u_match (
        .tags(tags), .want(req_tag), .hit(hit), .idx(hit_idx)
    );

    assign cs = st_q.s[st_q.cur];

    sdma_chunk #(.LEN_W(LEN_W)) u_chunk (
        .left(st_q.left), .cbl(cs.cbl), .lpib(cs.lpib),
        .elen(desc_len), .bp(cs.bp), .chunk(chunk), .ent_end(ent_end)
    );

    always_comb begin
        st_d     = st_q;
        old_c    = '0;
        new_c    = '0;
        nxt_lpib = cs.lpib + chunk;
        nxt_bp   = cs.bp + chunk;
        nxt_left = st_q.left - chunk;

        // Software register writes
        if (reg_we && (int'(reg_sel) < NUM_STREAMS)) begin
            case (reg_field)
                FLD_CTL: begin
                    old_c = st_q.s[reg_sel].ctl;
                    new_c = (old_c & ~CTL_WMASK) | (reg_wdata & CTL_WMASK);
                    new_c = new_c & ~(reg_wdata & CTL_W1C);
                    st_d.s[reg_sel].ctl = new_c;
                    if (new_c[SRST_BIT]) begin
                        st_d.s[reg_sel].lpib = '0;
                        st_d.s[reg_sel].be   = '0;
                        st_d.s[reg_sel].bp   = '0;
                    end else if (new_c[RUN_BIT] && !old_c[RUN_BIT]) begin
                        st_d.s[reg_sel].be = '0;
                        st_d.s[reg_sel].bp = '0;
                    end
                end
                FLD_CBL: st_d.s[reg_sel].cbl = reg_wdata[LEN_W-1:0];
                FLD_LVI: st_d.s[reg_sel].lvi = reg_wdata[ENT_W-1:0];
                default: ;
            endcase
        end

        // Transfer engine
        case (st_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!hit || !st_q.s[hit_idx].ctl[RUN_BIT] ||
                        st_q.s[hit_idx].ctl[CMPL_BIT]) begin
                        st_d.fsm = ST_REJ;
                    end else begin
                        st_d.cur  = hit_idx;
                        st_d.left = req_len;
                        st_d.dir  = req_dir;
                        st_d.pend = 1'b0;
                        st_d.fsm  = (req_len == '0) ? ST_FIN : ST_MOVE;
                    end
                end
            end
            ST_MOVE: begin
                st_d.left = nxt_left;
                st_d.s[st_q.cur].lpib = (nxt_lpib >= cs.cbl) ? '0 : nxt_lpib;
                if (ent_end) begin
                    if (desc_ioc) st_d.pend = 1'b1;
                    st_d.s[st_q.cur].bp = '0;
                    st_d.s[st_q.cur].be = (cs.be >= cs.lvi) ? '0 : cs.be + 1'b1;
                end else begin
                    st_d.s[st_q.cur].bp = nxt_bp;
                end
                if (nxt_left == '0 || (chunk == '0 && !ent_end)) st_d.fsm = ST_FIN;
            end
            ST_FIN: begin
                if (st_q.pend) st_d.s[st_q.cur].ctl[CMPL_BIT] = 1'b1;
                st_d.fsm = ST_IDLE;
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle        = (st_q.fsm == ST_IDLE);
    assign done        = (st_q.fsm == ST_FIN) || (st_q.fsm == ST_REJ);
    assign done_ok     = (st_q.fsm == ST_FIN);
    assign desc_stream = st_q.cur;
    assign desc_entry  = cs.be;
    assign mem_valid   = (st_q.fsm == ST_MOVE);
    assign mem_dir     = st_q.dir;
    assign mem_addr    = desc_addr + 64'(cs.bp);
    assign mem_len     = chunk;
    assign wb_valid    = (st_q.fsm == ST_FIN) && pos_base[0];
    assign wb_addr     = {pos_base[31:1], 1'b0} + (32'(st_q.cur) << 3);
    assign wb_data     = cs.lpib;
    assign rd_ctl      = st_q.s[rd_sel].ctl;
    assign rd_lpib     = st_q.s[rd_sel].lpib;

    AST_MOVE_WITHIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_len <= st_q.left); // R3
    AST_MOVE_WITHIN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && cs.lpib < cs.cbl) |-> mem_len <= cs.cbl - cs.lpib); // R3
    AST_NO_MOVE_WHILE_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !cs.ctl[CMPL_BIT]); // R2
    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_valid) |=> !idle); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_WB_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (done && done_ok)); // R7
    AST_CMPL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs.ctl[CMPL_BIT]) |-> $past(st_q.fsm == ST_FIN)); // R6
endmodule

// File: tb/sdma_engine_test.sv
module sdma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [0:0]  reg_sel = '0;
    logic [1:0]  reg_field = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] pos_base = '0;
    logic [0:0]  rd_sel = '0;
    logic [31:0] rd_ctl;
    logic [31:0] rd_lpib;
    logic        req_valid = 1'b0;
    logic [3:0]  req_tag = '0;
    logic        req_dir = 1'b0;
    logic [31:0] req_len = '0;
    logic        idle, done, done_ok;
    logic [0:0]  desc_stream;
    logic [7:0]  desc_entry;
    logic [63:0] desc_addr;
    logic [31:0] desc_len;
    logic        desc_ioc;
    logic        mem_valid, mem_dir;
    logic [63:0] mem_addr;
    logic [31:0] mem_len;
    logic        wb_valid;
    logic [31:0] wb_addr;
    logic [31:0] wb_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [63:0] m_addr [0:1][0:3];
    logic [31:0] m_len  [0:1][0:3];
    logic        m_ioc  [0:1][0:3];

    // results of the last transfer
    int          n_ops, first_cyc, done_cyc;
    logic        r_ok, r_wb;
    logic [63:0] op_addr [0:7];
    logic [31:0] op_len  [0:7];
    logic [31:0] r_wb_addr, r_wb_data;

    always #5 clk = ~clk;

    always_comb begin
        desc_addr = m_addr[desc_stream][desc_entry[1:0]];
        desc_len  = m_len[desc_stream][desc_entry[1:0]];
        desc_ioc  = m_ioc[desc_stream][desc_entry[1:0]];
    end

    sdma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_field(reg_field), .reg_wdata(reg_wdata), .pos_base(pos_base),
        .rd_sel(rd_sel), .rd_ctl(rd_ctl), .rd_lpib(rd_lpib),
        .req_valid(req_valid), .req_tag(req_tag), .req_dir(req_dir),
        .req_len(req_len), .idle(idle), .done(done), .done_ok(done_ok),
        .desc_stream(desc_stream), .desc_entry(desc_entry),
        .desc_addr(desc_addr), .desc_len(desc_len), .desc_ioc(desc_ioc),
        .mem_valid(mem_valid), .mem_dir(mem_dir), .mem_addr(mem_addr),
        .mem_len(mem_len), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [1:0] fld, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'(sel); reg_field = fld; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic peek(input int sel);
        rd_sel = 1'(sel);
        #1;
    endtask

    task automatic xfer(input logic [3:0] tag, input logic [31:0] len);
        int cyc;
        @(negedge clk);
        req_valid = 1'b1; req_tag = tag; req_len = len; req_dir = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_ops = 0; first_cyc = -1; done_cyc = -1; r_ok = 0; r_wb = 0;
        cyc = 0;
        while (done_cyc < 0 && cyc < 40) begin
            if (mem_valid && n_ops < 8) begin
                if (first_cyc < 0) first_cyc = cyc;
                op_addr[n_ops] = mem_addr;
                op_len[n_ops]  = mem_len;
                n_ops++;
            end
            if (done) begin
                done_cyc = cyc; r_ok = done_ok; r_wb = wb_valid;
                r_wb_addr = wb_addr; r_wb_data = wb_data;
            end
            cyc++;
            if (done_cyc < 0) @(negedge clk);
        end
        @(negedge clk);   // status and positions settle one edge after done
    endtask

    task automatic t_reset;
        peek(0);
        chk("R11 idle after reset", idle, 1);
        chk("R11 done low after reset", done, 0);
        chk("R11 no op after reset", mem_valid, 0);
        chk("R8 control zero after reset", rd_ctl, 0);
        chk("R4 position zero after reset", rd_lpib, 0);
    endtask

    task automatic t_no_match;
        xfer(4'd9, 32'd10);
        chk("R1 unmatched tag refused", r_ok, 0);
        chk("R1 unmatched tag no ops", n_ops, 0);
        chk("R11 refusal done next cycle", done_cyc, 0);
    endtask

    task automatic t_not_running;
        wr(0, 2'd0, 32'h0050_0000);
        xfer(4'd5, 32'd10);
        chk("R2 stopped stream refused", r_ok, 0);
        chk("R2 stopped stream no ops", n_ops, 0);
        wr(0, 2'd0, 32'h0050_0002);
    endtask

    task automatic t_single;
        xfer(4'd5, 32'd30);
        chk("R3 single op count", n_ops, 1);
        chk("R5 single op addr", op_addr[0], 64'h1000);
        chk("R3 single op len", op_len[0], 30);
        chk("R11 first op cycle", first_cyc, 0);
        chk("R11 done after last op", done_cyc, 1);
        chk("R1 success", r_ok, 1);
        chk("R7 no writeback when disabled", r_wb, 0);
        peek(0);
        chk("R4 position after single", rd_lpib, 30);
    endtask

    task automatic t_entry_split;
        xfer(4'd5, 32'd30);
        chk("R3 entry split count", n_ops, 2);
        chk("R5 split op0 addr", op_addr[0], 64'h101E);
        chk("R3 split op0 len", op_len[0], 18);
        chk("R5 split op1 addr next entry", op_addr[1], 64'h2000);
        chk("R3 split op1 len", op_len[1], 12);
        chk("R11 done after two ops", done_cyc, 2);
        peek(0);
        chk("R4 position after split", rd_lpib, 60);
        chk("R6 no completion without flag", rd_ctl[26], 0);
    endtask

    task automatic t_wrap_ioc;
        pos_base = 32'h0000_8001;
        xfer(4'd5, 32'd50);
        pos_base = 32'h0;
        chk("R3 wrap op count", n_ops, 3);
        chk("R5 wrap op0 addr", op_addr[0], 64'h200C);
        chk("R3 wrap op0 len", op_len[0], 20);
        chk("R5 wrap op1 addr", op_addr[1], 64'h3000);
        chk("R3 ring limit len", op_len[1], 20);
        chk("R5 wrap op2 addr", op_addr[2], 64'h3014);
        chk("R3 wrap op2 len", op_len[2], 10);
        chk("R7 writeback present", r_wb, 1);
        chk("R7 writeback addr stream0", r_wb_addr, 32'h8000);
        chk("R7 writeback data", r_wb_data, 10);
        peek(0);
        chk("R4 position wrapped", rd_lpib, 10);
        chk("R6 completion raised", rd_ctl[26], 1);
    endtask

    task automatic t_stall;
        xfer(4'd5, 32'd10);
        chk("R2 refused while completion set", r_ok, 0);
        chk("R2 no ops while completion set", n_ops, 0);
        peek(0);
        chk("R2 position unchanged", rd_lpib, 10);
    endtask

    task automatic t_ack_and_list_wrap;
        wr(0, 2'd0, 32'h0450_0F02);
        peek(0);
        chk("R8 w1c and mask", rd_ctl, 32'h0050_0002);
        xfer(4'd5, 32'd10);
        chk("R5 last entry addr", op_addr[0], 64'h301E);
        chk("R3 last entry len", op_len[0], 10);
        peek(0);
        chk("R6 unflagged entry no completion", rd_ctl[26], 0);
        xfer(4'd5, 32'd5);
        chk("R5 list wraps to entry 0", op_addr[0], 64'h1000);
        peek(0);
        chk("R4 position after list wrap", rd_lpib, 25);
    endtask

    task automatic t_stream1;
        wr(1, 2'd1, 32'd64);
        wr(1, 2'd2, 32'd0);
        wr(1, 2'd0, 32'h0030_0002);
        pos_base = 32'h0000_8001;
        xfer(4'd3, 32'd16);
        chk("R1 second stream addr", op_addr[0], 64'h5000);
        chk("R7 writeback addr stream1", r_wb_addr, 32'h8008);
        chk("R7 writeback data stream1", r_wb_data, 16);
        xfer(4'd3, 32'd48);
        pos_base = 32'h0;
        chk("R3 exact fit len", op_len[0], 48);
        chk("R7 writeback wrapped data", r_wb_data, 0);
        peek(1);
        chk("R4 wrap at exact length", rd_lpib, 0);
        chk("R6 single entry completion", rd_ctl[26], 1);
    endtask

    task automatic t_priority;
        wr(1, 2'd0, 32'h0450_0002);
        xfer(4'd5, 32'd3);
        chk("R1 lowest index wins", op_addr[0], 64'h1005);
        peek(1);
        chk("R1 higher stream untouched", rd_lpib, 0);
        peek(0);
        chk("R1 lower stream advanced", rd_lpib, 28);
    endtask

    task automatic t_stream_reset;
        wr(0, 2'd0, 32'h0050_0003);
        peek(0);
        chk("R9 reset clears position", rd_lpib, 0);
        wr(0, 2'd0, 32'h0050_0002);
        xfer(4'd5, 32'd4);
        chk("R9 reset returns to entry 0", op_addr[0], 64'h1000);
    endtask

    task automatic t_restart;
        wr(0, 2'd0, 32'h0050_0000);
        xfer(4'd5, 32'd4);
        chk("R2 stopped lowest match refused", r_ok, 0);
        wr(0, 2'd0, 32'h0050_0002);
        xfer(4'd5, 32'd4);
        chk("R10 restart at entry 0 offset 0", op_addr[0], 64'h1000);
        peek(0);
        chk("R10 position kept across restart", rd_lpib, 8);
    endtask

    initial begin
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 4; e++) begin
                m_addr[s][e] = 64'h0; m_len[s][e] = 32'd16; m_ioc[s][e] = 1'b0;
            end
        m_addr[0][0] = 64'h1000; m_len[0][0] = 32'd48;
        m_addr[0][1] = 64'h2000; m_len[0][1] = 32'd32; m_ioc[0][1] = 1'b1;
        m_addr[0][2] = 64'h3000; m_len[0][2] = 32'd40;
        m_addr[1][0] = 64'h5000; m_len[1][0] = 32'd64; m_ioc[1][0] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(0, 2'd1, 32'd100);
        wr(0, 2'd2, 32'd2);
        t_no_match();
        t_not_running();
        t_single();
        t_entry_split();
        t_wrap_ioc();
        t_stall();
        t_ack_and_list_wrap();
        t_stream1();
        t_priority();
        t_stream_reset();
        t_restart();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule